// File: doc/BRIEF.md
# Serial Bit-Addressable I/O Controller

This block sits between a processor's execution stage and a serial I/O bus on which every peripheral flag, control line or data pin has its own bit address. The processor hands over one request: an operation, the current contents of the software base register, a signed 8-bit displacement, a bit count and a data word. The controller then drives the bus one bit per clock. Each bus cycle carries a 12-bit bit address, a write-enable, an output data bit and a strobe. Each bus cycle also samples an input data bit.

Single-bit requests can drive one addressed bit high, drive it low, or sample it for a condition flag. Multi-bit requests move up to sixteen bits of a data word serially across consecutive bit addresses. An output transfer shifts the word out. An input transfer assembles the sampled bits into a result word. A one-cycle completion pulse marks the point where the flag or the assembled word is valid. Decoding the instruction and modelling the peripherals are left to the surrounding logic.

Top module: `bitio_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `bus_strobe_o` and `bus_we_o` are low, and `store_word_o` and `test_eq_o` are zero.
- R2: A single-bit request (op 1, 2 or 3) uses bit address `base[12:1] + sign_extend(disp)`, taken modulo 4096.
- R3: Op 1 (set) produces exactly one bus cycle, in the cycle after acceptance, with `bus_strobe_o`, `bus_we_o` and `bus_dout_o` all high.
- R4: Op 2 (clear) produces exactly one bus cycle with `bus_strobe_o` and `bus_we_o` high and `bus_dout_o` low.
- R5: Op 3 (test) produces one bus cycle with `bus_we_o` low. At completion, `test_eq_o` takes the value of `bus_din_i` sampled in that cycle; a 1 means equal.
- R6: A multi-bit request (op 4 or 5) ignores `req_disp_i` and starts at bit address `base[12:1]`. The address rises by one in each following bus cycle and wraps modulo 4096. The request moves `req_count_i` bits, where a count of 0 means 16.
- R7: Op 4 (output transfer) drives the operand least significant bit first, with `bus_we_o` high. Counts 1 to 8 take the operand from `req_data_i[15:8]`. Counts 9 to 15 and 0 take it from `req_data_i[15:0]`.
- R8: Op 5 (input transfer) keeps `bus_we_o` low and places the bit sampled in bus cycle i into result bit i. For counts 9 to 15 and 0, the result is right-justified in `store_word_o` with the unused high bits zero. For counts 1 to 8, result bit i goes to `store_word_o[8+i]` and every other bit is zero.
- R9: `busy_o` and `bus_strobe_o` stay high for exactly n consecutive cycles for an n-bit request. `done_o` is high for exactly the one cycle that follows the last bus cycle.
- R10: A request raised while `busy_o` is high has no effect. A request with op 0, 6 or 7 has no effect.
- R11: `store_word_o` changes only when an input transfer completes, and `test_eq_o` changes only when a test completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_op_i | input | 3 | Operation code: 1 set, 2 clear, 3 test, 4 output transfer, 5 input transfer |
| req_base_i | input | 16 | Software base register value |
| req_disp_i | input | 8 | Signed bit displacement for single-bit ops |
| req_count_i | input | 4 | Bit count for transfers, 0 means 16 |
| req_data_i | input | 16 | Operand word for output transfers |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| test_eq_o | output | 1 | Result of the last test |
| store_word_o | output | 16 | Result of the last input transfer |
| bus_addr_o | output | 12 | Bit address of the current bus cycle |
| bus_dout_o | output | 1 | Output data bit |
| bus_we_o | output | 1 | Bus cycle writes the addressed bit |
| bus_strobe_o | output | 1 | Bus cycle valid |
| bus_din_i | input | 1 | Input data bit of the addressed location |

## Verification
A request taken at clock edge k produces its first bus cycle right after edge k. Bit i of an n-bit request is on the bus between edges k+i and k+i+1. The edge k+n raises `done_o` together with the new `test_eq_o` or `store_word_o`. The bench drives each request on a falling edge and samples every output on the following falling edges, collecting the bus bits into a word and counting cycles from acceptance. This places each comparison in the half-cycle where the result is due, and the count confirms that `done_o` comes exactly one cycle after the last strobe.

// File: rtl/bitio_pkg.sv
// Shared definitions for the serial bit-addressable I/O controller.
// Assumes the operation code arrives already decoded from the instruction.
package bitio_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_SET   = 3'd1,
        OP_CLR   = 3'd2,
        OP_TEST  = 3'd3,
        OP_LOAD  = 3'd4,
        OP_STORE = 3'd5
    } bitio_op_e;

    // True for codes that start a bus sequence.
    function automatic logic op_is_valid(input logic [2:0] op);
        return (op >= 3'd1) && (op <= 3'd5);
    endfunction

    // True for single-bit operations, which use the displacement.
    function automatic logic op_is_single(input logic [2:0] op);
        return (op >= 3'd1) && (op <= 3'd3);
    endfunction

    // True for operations that drive data onto the bus.
    function automatic logic op_is_write(input logic [2:0] op);
        return (op == OP_SET) || (op == OP_CLR) || (op == OP_LOAD);
    endfunction

endpackage

// File: rtl/bitio_addr.sv
// Start-address generator.
// Forms the first bit address from the word-aligned base register value
// (bit 0 dropped) plus an optional sign-extended displacement. The sum wraps
// modulo 2**AW. Assumes DW > AW and AW > DISPW.
module bitio_addr #(
    parameter int DW    = 16,
    parameter int AW    = 12,
    parameter int DISPW = 8
) (
    input  logic [DW-1:0]    base_i,
    input  logic [DISPW-1:0] disp_i,
    input  logic             use_disp_i,
    output logic [AW-1:0]    start_addr_o
);

    logic [AW-1:0] base_bits;
    logic [AW-1:0] disp_ext;

    // Sign-extend the displacement and add it to the base bits.
    always_comb begin
        base_bits    = base_i[AW:1];
        disp_ext     = use_disp_i ? {{(AW-DISPW){disp_i[DISPW-1]}}, disp_i} : '0;
        start_addr_o = base_bits + disp_ext;
    end

endmodule

// File: rtl/bitio_seq.sv
// Bit-cycle sequencer.
// Keeps busy high for exactly nbits cycles after a start pulse and raises a
// one-cycle done pulse after the last bit cycle. Assumes nbits is 1..2**(NW-1).
module bitio_seq #(
    parameter int NW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NW-1:0] nbits_i,
    output logic          busy_o,
    output logic          last_o,
    output logic          done_o
);

    logic [NW-1:0] remain_q;

    // Flag the final bit cycle.
    always_comb last_o = busy_o && (remain_q == '0);

    // Count bit cycles down and form the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o   <= 1'b0;
            remain_q <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= last_o;
            if (start_i) begin
                busy_o   <= 1'b1;
                remain_q <= nbits_i - NW'(1);
            end else if (busy_o) begin
                if (remain_q == '0) busy_o <= 1'b0;
                else                remain_q <= remain_q - NW'(1);
            end
        end
    end

endmodule

// File: rtl/bitio_shift.sv
// Serial data path.
// Shifts the outgoing operand out LSB first and collects incoming bits into a
// result word. Also captures the single-bit test flag. In byte mode the
// operand comes from the upper half of the data word, and the result is placed
// in the upper half. Assumes DW is even.
module bitio_shift
    import bitio_pkg::*;
#(
    parameter int DW = 16,
    parameter int NW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    op_i,
    input  logic [DW-1:0] data_i,
    input  logic          byte_mode_i,
    input  logic [NW-1:0] nbits_i,
    input  logic          busy_i,
    input  logic          last_i,
    input  logic          din_i,
    output logic          dout_o,
    output logic [DW-1:0] store_word_o,
    output logic          test_eq_o
);

    localparam int HW = DW / 2;

    logic [2:0]    op_q;
    logic          byte_q;
    logic [NW-1:0] nbits_q;
    logic [DW-1:0] out_sh_q;
    logic [DW-1:0] in_sh_q;
    logic [DW-1:0] in_next;
    logic [NW-1:0] align_amt;
    logic [DW-1:0] aligned;
    logic [DW-1:0] placed;

    // Present the current outgoing bit.
    always_comb dout_o = out_sh_q[0];

    // Right-justify the gathered bits and move them to the upper half in byte mode.
    always_comb begin
        in_next   = {din_i, in_sh_q[DW-1:1]};
        align_amt = NW'(DW) - nbits_q;
        aligned   = in_next >> align_amt;
        placed    = byte_q ? {aligned[HW-1:0], {HW{1'b0}}} : aligned;
    end

    // Load the shifters at start and step them in every bit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            byte_q   <= 1'b0;
            nbits_q  <= '0;
            out_sh_q <= '0;
            in_sh_q  <= '0;
        end else if (start_i) begin
            op_q    <= op_i;
            byte_q  <= byte_mode_i;
            nbits_q <= nbits_i;
            in_sh_q <= '0;
            case (op_i)
                OP_SET:  out_sh_q <= DW'(1);
                OP_LOAD: out_sh_q <= byte_mode_i ? DW'(data_i[DW-1:HW]) : data_i;
                default: out_sh_q <= '0;
            endcase
        end else if (busy_i) begin
            out_sh_q <= out_sh_q >> 1;
            in_sh_q  <= in_next;
        end
    end

    // Update the visible results only when the matching operation completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_word_o <= '0;
            test_eq_o    <= 1'b0;
        end else if (last_i) begin
            if (op_q == OP_STORE) store_word_o <= placed;
            if (op_q == OP_TEST)  test_eq_o    <= din_i;
        end
    end

endmodule

// File: rtl/bitio_ctrl.sv
// Serial bit-addressable I/O controller, top level.
// Accepts one request while idle and runs it as a sequence of one-bit bus
// cycles at consecutive addresses. Requests that arrive while busy, and
// unused op codes, are dropped. Assumes the requester holds a request until
// it sees busy_o, or pulses it only while idle.
module bitio_ctrl
    import bitio_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 12,
    parameter int DISPW = 8,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [2:0]       req_op_i,
    input  logic [DW-1:0]    req_base_i,
    input  logic [DISPW-1:0] req_disp_i,
    input  logic [CW-1:0]    req_count_i,
    input  logic [DW-1:0]    req_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             test_eq_o,
    output logic [DW-1:0]    store_word_o,
    output logic [AW-1:0]    bus_addr_o,
    output logic             bus_dout_o,
    output logic             bus_we_o,
    output logic             bus_strobe_o,
    input  logic             bus_din_i
);

    localparam int NW = $clog2(DW) + 1;

    logic          start;
    logic          single;
    logic [NW-1:0] nbits;
    logic          byte_mode;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] addr_q;
    logic          we_q;
    logic          last;

    // Decide acceptance, bit count and operand size for the incoming request.
    always_comb begin
        start     = req_valid_i && !busy_o && op_is_valid(req_op_i);
        single    = op_is_single(req_op_i);
        if (single)                 nbits = NW'(1);
        else if (req_count_i == '0) nbits = NW'(DW);
        else                        nbits = NW'(req_count_i);
        byte_mode = !single && (req_count_i != '0) && (NW'(req_count_i) <= NW'(DW / 2));
    end

    bitio_addr #(.DW(DW), .AW(AW), .DISPW(DISPW)) u_addr (
        .base_i       (req_base_i),
        .disp_i       (req_disp_i),
        .use_disp_i   (single),
        .start_addr_o (start_addr)
    );

    bitio_seq #(.NW(NW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .nbits_i (nbits),
        .busy_o  (busy_o),
        .last_o  (last),
        .done_o  (done_o)
    );

    bitio_shift #(.DW(DW), .NW(NW)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .op_i         (req_op_i),
        .data_i       (req_data_i),
        .byte_mode_i  (byte_mode),
        .nbits_i      (nbits),
        .busy_i       (busy_o),
        .last_i       (last),
        .din_i        (bus_din_i),
        .dout_o       (bus_dout_o),
        .store_word_o (store_word_o),
        .test_eq_o    (test_eq_o)
    );

    // Hold the bus address and direction; step the address after each bit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            we_q   <= 1'b0;
        end else if (start) begin
            addr_q <= start_addr;
            we_q   <= op_is_write(req_op_i);
        end else if (busy_o) begin
            addr_q <= addr_q + AW'(1);
        end
    end

    // Drive the bus-side qualifiers.
    always_comb begin
        bus_addr_o   = addr_q;
        bus_strobe_o = busy_o;
        bus_we_o     = busy_o && we_q;
    end

endmodule

// File: rtl/bitio_ctrl_chk.sv
// Protocol checker for bitio_ctrl, attached by bind below.
// Relates bus qualifiers, the address sequence, the completion pulse and the
// result registers over time.
module bitio_ctrl_chk #(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_strobe_o,
    input logic          bus_we_o,
    input logic [AW-1:0] bus_addr_o,
    input logic          done_o,
    input logic [DW-1:0] store_word_o,
    input logic          test_eq_o
);

    // R3 R4: a write is only ever qualified by a live bus cycle.
    assert_we_in_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we_o |-> bus_strobe_o);

    // R6: back-to-back bus cycles step the address by one.
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe_o && $past(bus_strobe_o)) |-> (bus_addr_o == $past(bus_addr_o) + AW'(1)));

    // R9: the end of a burst of bus cycles is marked by done.
    assert_done_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_strobe_o) |-> done_o);

    // R9: done lasts one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: the input-transfer result moves only with a completion.
    assert_store_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(store_word_o) |-> done_o);

    // R11: the test flag moves only with a completion.
    assert_test_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(test_eq_o) |-> done_o);

endmodule

bind bitio_ctrl bitio_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_strobe_o (bus_strobe_o),
    .bus_we_o     (bus_we_o),
    .bus_addr_o   (bus_addr_o),
    .done_o       (done_o),
    .store_word_o (store_word_o),
    .test_eq_o    (test_eq_o)
);

// File: tb/sim_bitio_ctrl.sv
`timescale 1ns/1ps
// Bench for bitio_ctrl: a vector table walked by one loop, then directed
// checks for reset, dropped requests and result holding.
module sim_bitio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [15:0] req_base = '0;
    logic [7:0]  req_disp = '0;
    logic [3:0]  req_count = '0;
    logic [15:0] req_data = '0;
    logic        busy, done, test_eq, bus_dout, bus_we, bus_strobe, bus_din;
    logic [15:0] store_word;
    logic [11:0] bus_addr;

    logic [15:0] cur_pat = '0;
    logic [11:0] cur_start = '0;
    logic [11:0] rel;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // Peripheral model: input bit i of the current pattern at start address + i.
    always_comb begin
        rel     = bus_addr - cur_start;
        bus_din = cur_pat[rel[3:0]];
    end

    bitio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
        .req_base_i(req_base), .req_disp_i(req_disp), .req_count_i(req_count),
        .req_data_i(req_data), .busy_o(busy), .done_o(done), .test_eq_o(test_eq),
        .store_word_o(store_word), .bus_addr_o(bus_addr), .bus_dout_o(bus_dout),
        .bus_we_o(bus_we), .bus_strobe_o(bus_strobe), .bus_din_i(bus_din)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] base;
        logic [7:0]  disp;
        logic [3:0]  cnt;
        logic [15:0] data;
        logic [15:0] pat;
        logic [11:0] addr;
        logic [4:0]  n;
        logic [15:0] val;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 16'h0040, 8'h05, 4'd0,  16'h0000, 16'h0000, 12'h025, 5'd1,  16'h0001}, // R2 R3
        '{3'd2, 16'h0040, 8'hFE, 4'd0,  16'h0000, 16'h0000, 12'h01E, 5'd1,  16'h0000}, // R2 R4
        '{3'd3, 16'h0000, 8'h03, 4'd0,  16'h0000, 16'h0001, 12'h003, 5'd1,  16'h0001}, // R5
        '{3'd3, 16'h0100, 8'h80, 4'd0,  16'h0000, 16'h0000, 12'h000, 5'd1,  16'h0000}, // R2 R5
        '{3'd1, 16'h0000, 8'hFF, 4'd0,  16'h0000, 16'h0000, 12'hFFF, 5'd1,  16'h0001}, // R2 wrap
        '{3'd4, 16'h0010, 8'h33, 4'd8,  16'hA53C, 16'h0000, 12'h008, 5'd8,  16'h00A5}, // R6 R7 byte
        '{3'd4, 16'h0020, 8'h00, 4'd12, 16'h1ABC, 16'h0000, 12'h010, 5'd12, 16'h0ABC}, // R7 word
        '{3'd4, 16'h0000, 8'h00, 4'd0,  16'hBEEF, 16'h0000, 12'h000, 5'd16, 16'hBEEF}, // R6 count 0
        '{3'd5, 16'h0006, 8'h00, 4'd8,  16'h0000, 16'h12C3, 12'h003, 5'd8,  16'hC300}, // R8 byte
        '{3'd5, 16'h0002, 8'h00, 4'd5,  16'h0000, 16'hFFFF, 12'h001, 5'd5,  16'h1F00}, // R8 byte short
        '{3'd5, 16'h0000, 8'h00, 4'd10, 16'h0000, 16'hFFFF, 12'h000, 5'd10, 16'h03FF}, // R8 word
        '{3'd5, 16'h1FFE, 8'h00, 4'd0,  16'h0000, 16'h8001, 12'hFFF, 5'd16, 16'h8001}, // R6 R8 wrap
        '{3'd4, 16'h0002, 8'h00, 4'd1,  16'h0100, 16'h0000, 12'h001, 5'd1,  16'h0001}  // R7 count 1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request on a falling edge; it is taken at the next rising edge.
    task automatic issue(input logic [2:0] op, input logic [15:0] base, input logic [7:0] disp,
                         input logic [3:0] cnt, input logic [15:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_base = base;
        req_disp = disp; req_count = cnt; req_data = data;
    endtask

    // Run one table vector and compare every observable result.
    task automatic run_vec(input vec_t v, input int idx);
        int strobes = 0;
        int last_c = -10;
        int done_c = -1;
        logic [15:0] got = '0;
        logic [11:0] first = '0;
        logic [11:0] prev = '0;
        logic addr_ok = 1'b1;
        logic we_ok = 1'b1;
        logic exp_we;
        logic [15:0] val;
        exp_we    = (v.op == 3'd1) || (v.op == 3'd2) || (v.op == 3'd4);
        cur_pat   = v.pat;
        cur_start = v.addr;
        issue(v.op, v.base, v.disp, v.cnt, v.data);
        for (int c = 0; c < 40 && done_c < 0; c++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (bus_strobe) begin
                if (strobes == 0) first = bus_addr;
                else if (bus_addr !== prev + 12'd1) addr_ok = 1'b0;
                prev = bus_addr;
                if (bus_we !== exp_we) we_ok = 1'b0;
                if (strobes < 16) got[strobes] = bus_dout;
                strobes++;
                last_c = c;
            end
            if (done) done_c = c;
        end
        case (v.op)
            3'd3:    val = {15'b0, test_eq};
            3'd5:    val = store_word;
            default: val = got;
        endcase
        chk($sformatf("R9 vec%0d bit cycles", idx), strobes, v.n);
        chk($sformatf("R2 R6 vec%0d first address", idx), first, v.addr);
        chk($sformatf("R6 vec%0d address steps", idx), addr_ok, 1);
        chk($sformatf("R3 R4 R5 vec%0d write enable", idx), we_ok, 1);
        chk($sformatf("R9 vec%0d done timing", idx), done_c, last_c + 1);
        chk($sformatf("R3 R4 R5 R7 R8 vec%0d value", idx), val, v.val);
        @(negedge clk);
        chk($sformatf("R9 vec%0d done one cycle", idx), done, 0);
    endtask

    // Count bus cycles over a window; used to show a request was dropped.
    task automatic quiet(input int ncyc, input string tag);
        int seen = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (bus_strobe || done) seen++;
        end
        chk(tag, seen, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held and just after release
        chk("R1 busy", busy, 0);
        chk("R1 strobe", bus_strobe, 0);
        chk("R1 we", bus_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 store_word", store_word, 0);
        chk("R1 test_eq", test_eq, 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R11: a set leaves the earlier store result (8001) and test flag (0) alone
        issue(3'd1, 16'h0000, 8'h01, 4'd0, 16'h0000);
        @(negedge clk); req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 store_word held", store_word, 16'h8001);
        chk("R11 test_eq held", test_eq, 0);

        // R10: a set raised mid-transfer at address 0x400 is dropped
        cur_start = 12'h000; cur_pat = 16'h0000;
        issue(3'd4, 16'h0000, 8'h00, 4'd0, 16'hFFFF);
        begin
            int strobes = 0;
            int far = 0;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (c == 0) req_valid = 1'b0;
                if (c == 4) begin
                    req_valid = 1'b1; req_op = 3'd1; req_base = 16'h0800; req_disp = 8'h00;
                end
                if (c == 5) req_valid = 1'b0;
                if (bus_strobe) begin
                    strobes++;
                    if (bus_addr >= 12'h010) far++;
                end
            end
            chk("R10 busy request dropped, cycles", strobes, 16);
            chk("R10 busy request dropped, address", far, 0);
        end

        // R10: unused op codes start nothing
        issue(3'd6, 16'h0000, 8'h00, 4'd3, 16'h0000);
        quiet(5, "R10 op 6 ignored");
        issue(3'd0, 16'h0000, 8'h00, 4'd3, 16'h0000);
        quiet(5, "R10 op 0 ignored");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule